// File: doc/BRIEF.md
# DMA Fault Recovery Sequencer

This block is the control sequencer that a token-passing bus station runs when one of its own DMA cycles fails. There are two kinds of failure. The first is a bus error signalled on a pin while the station owns the host bus. The second is a self-addressing error: the station owns the bus and sees its own chip-select or interrupt-acknowledge input asserted. On a failure the sequencer stops the frame transmit and receive machines. If the station holds the token, it gets rid of the token. It then writes the station's four DMA pointers and their function codes into a fixed dump region, raises a status flag, and interrupts the host if the mask allows it.

Token disposal goes through two request/done handshakes: one to pass the token and one to search for a successor. Both protocols live outside this block. The dump leaves through a one-word-per-cycle valid/ready write port. While `dump_valid` is high and `dump_ready` is low, the word and its address are held, and the sequencer stalls without limit. A word counts as written on a clock edge where both are high.

After the host has repaired things, it pulses `host_clear` and normal operation resumes. Two cases send the block into a terminal severe state that only reset leaves: a second failure before that clear, or any failure while the station is offline.

Top module: `fault_recovery_seq`

## Requirements
- R1: After reset `tx_en` and `rx_en` are 1, and `pass_req`, `find_req`, `dump_valid`, `err_status`, `irq` and `severe` are 0.
- R2: A fault is detected at a clock edge where `bus_master` is 1 and at least one of `bus_err_in`, `chip_sel`, `int_ack` is 1. With `bus_master` at 0 those inputs have no effect. `host_clear` has no effect during normal operation.
- R3: From the cycle after a detected fault, `tx_en` and `rx_en` are 0. They stay 0 until the host clear is taken.
- R4: If `token_held` and `succ_known` are both 1 at the fault edge, `pass_req` is high from the next cycle until the edge where `pass_done` is seen, and `find_req` stays 0.
- R5: If `token_held` is 1 and `succ_known` is 0, `find_req` is high until `find_done` is seen. `pass_req` then follows as in R4. The two requests are never high together.
- R6: If `token_held` is 0 at the fault edge, `dump_valid` is 1 in the very next cycle and no request is raised.
- R7: The dump is eight words written in pair order i = 0..3. Each pair is the function code of pointer i (zero-extended to 32 bits) at byte address 0xE0+6i, then pointer i at 0xE2+6i. The last word therefore sits at 0xF4.
- R8: While `dump_valid` is 1 and `dump_ready` is 0, `dump_valid` stays 1 and `dump_addr` and `dump_data` do not change.
- R9: In the cycle after the eighth word is accepted, `dump_valid` is 0, `err_status` is 1 and `irq` equals `irq_mask`.
- R10: A `host_clear` seen while the error status is set, with no new fault at the same edge, brings back `tx_en`/`rx_en` = 1, `err_status` = 0 and `irq` = 0 in the next cycle.
- R11: A fault at any edge after the first fault and before its clear (this includes an edge that also carries `host_clear`) sets `severe`. `severe` stays set until reset, whatever `host_clear` does.
- R12: A fault detected while `offline` is 1 sets `severe` in the next cycle, with no request and no dump word.
- R13: While `severe` is 1, `irq` is 1 regardless of `irq_mask`, `err_status` is 1, and `tx_en`, `rx_en` and `dump_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_master | input | 1 | Station currently owns the host bus (DMA cycle) |
| bus_err_in | input | 1 | Bus error reported by the host bus |
| chip_sel | input | 1 | Station's own chip-select input |
| int_ack | input | 1 | Station's own interrupt-acknowledge input |
| offline | input | 1 | Station is in its offline state |
| token_held | input | 1 | Station holds the token |
| succ_known | input | 1 | A successor station is known |
| host_clear | input | 1 | Host command clearing the error status bit |
| irq_mask | input | 1 | Interrupt mask bit for this error |
| pass_done | input | 1 | Token pass finished |
| find_done | input | 1 | Successor search finished |
| ptr_flat | input | 128 | Four 32-bit DMA pointers, pointer i at bits 32i+31:32i |
| fc_flat | input | 64 | Four 16-bit function codes, code i at bits 16i+15:16i |
| dump_ready | input | 1 | Dump write port can take a word |
| tx_en | output | 1 | Frame transmit enable |
| rx_en | output | 1 | Frame receive enable |
| pass_req | output | 1 | Request to pass the token |
| find_req | output | 1 | Request to search for a successor |
| dump_valid | output | 1 | Dump word is valid |
| dump_addr | output | 8 | Byte address of the dump word |
| dump_data | output | 32 | Dump word |
| err_status | output | 1 | Bus/address error status bit |
| irq | output | 1 | Interrupt to the host |
| severe | output | 1 | Terminal severe-interrupt state |

## Verification
The checker looks at every cycle for several things. It checks that the dump port holds its word under back-pressure and that the two token requests are exclusive. It checks that the enables drop the cycle after a fault and come back after a clean clear. It checks that the interrupt respects the mask outside the severe state, and that the severe state never lets go and forces its outputs. Some behaviours only the bench scenarios can show: the exact order, addresses and data of the eight dump words, the choice between pass and search for each token/successor combination, and the skipped token step. The same holds for escalation at each recovery stage, including a fault that arrives together with the clear.

// File: rtl/frs_pkg.sv
package frs_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_FIND,
    ST_PASS,
    ST_DUMP,
    ST_HOLD,
    ST_SEVERE
  } rec_state_t;
endpackage

// File: rtl/frs_fault_detect.sv
module frs_fault_detect (
  input  logic bus_master,
  input  logic bus_err_in,
  input  logic chip_sel,
  input  logic int_ack,
  output logic any_fault
);
  logic bus_fault;
  logic self_addr_fault;

  // A reported bus error only counts during the station's own bus tenure.
  assign bus_fault       = bus_master & bus_err_in;
  // Selecting ourselves while mastering the bus is an address error.
  assign self_addr_fault = bus_master & (chip_sel | int_ack);
  assign any_fault       = bus_fault | self_addr_fault;
endmodule

// File: rtl/frs_dump_seq.sv
module frs_dump_seq #(
  parameter int NPTR = 4,
  parameter int PTR_W = 32,
  parameter int FC_W = 16,
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = 8'hE0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  logic [NPTR*PTR_W-1:0] ptr_flat,
  input  logic [NPTR*FC_W-1:0]  fc_flat,
  input  logic                  dump_ready,
  output logic                  dump_valid,
  output logic [AW-1:0]         dump_addr,
  output logic [PTR_W-1:0]      dump_data,
  output logic                  last_accept
);
  localparam int WORDS      = 2 * NPTR;
  localparam int IDX_W      = $clog2(WORDS);
  localparam int FC_BYTES   = FC_W / 8;
  localparam int PAIR_BYTES = (PTR_W + FC_W) / 8;

  logic [IDX_W-1:0] idx;
  logic [PTR_W-1:0] word_tbl [WORDS];
  logic             accept;

  for (genvar g = 0; g < NPTR; g++) begin : g_unpack
    assign word_tbl[2*g]   = PTR_W'(fc_flat[g*FC_W +: FC_W]);
    assign word_tbl[2*g+1] = ptr_flat[g*PTR_W +: PTR_W];
  end

  assign dump_valid  = active;
  assign accept      = active & dump_ready;
  assign last_accept = accept & (idx == IDX_W'(WORDS - 1));
  assign dump_data   = word_tbl[idx];
  assign dump_addr   = BASE + AW'(idx >> 1) * AW'(PAIR_BYTES)
                     + (idx[0] ? AW'(FC_BYTES) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (!active) idx <= '0;
    else if (accept)  idx <= idx + 1'b1;
  end
endmodule

// File: rtl/fault_recovery_seq.sv
module fault_recovery_seq
  import frs_pkg::*;
#(
  parameter int NPTR = 4,
  parameter int PTR_W = 32,
  parameter int FC_W = 16,
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = 8'hE0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_master,
  input  logic                  bus_err_in,
  input  logic                  chip_sel,
  input  logic                  int_ack,
  input  logic                  offline,
  input  logic                  token_held,
  input  logic                  succ_known,
  input  logic                  host_clear,
  input  logic                  irq_mask,
  input  logic                  pass_done,
  input  logic                  find_done,
  input  logic [NPTR*PTR_W-1:0] ptr_flat,
  input  logic [NPTR*FC_W-1:0]  fc_flat,
  input  logic                  dump_ready,
  output logic                  tx_en,
  output logic                  rx_en,
  output logic                  pass_req,
  output logic                  find_req,
  output logic                  dump_valid,
  output logic [AW-1:0]         dump_addr,
  output logic [PTR_W-1:0]      dump_data,
  output logic                  err_status,
  output logic                  irq,
  output logic                  severe
);
  rec_state_t st, nxt;
  logic       any_fault;
  logic       last_accept;

  frs_fault_detect u_detect (
    .bus_master (bus_master),
    .bus_err_in (bus_err_in),
    .chip_sel   (chip_sel),
    .int_ack    (int_ack),
    .any_fault  (any_fault)
  );

  frs_dump_seq #(
    .NPTR(NPTR), .PTR_W(PTR_W), .FC_W(FC_W), .AW(AW), .BASE(BASE)
  ) u_dump (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (st == ST_DUMP),
    .ptr_flat    (ptr_flat),
    .fc_flat     (fc_flat),
    .dump_ready  (dump_ready),
    .dump_valid  (dump_valid),
    .dump_addr   (dump_addr),
    .dump_data   (dump_data),
    .last_accept (last_accept)
  );

  // Any fault outside normal operation escalates; it wins over a clear.
  always_comb begin
    nxt = st;
    unique case (st)
      ST_RUN: begin
        if (any_fault) begin
          if (offline)         nxt = ST_SEVERE;
          else if (token_held) nxt = succ_known ? ST_PASS : ST_FIND;
          else                 nxt = ST_DUMP;
        end
      end
      ST_FIND:   if (any_fault) nxt = ST_SEVERE; else if (find_done)   nxt = ST_PASS;
      ST_PASS:   if (any_fault) nxt = ST_SEVERE; else if (pass_done)   nxt = ST_DUMP;
      ST_DUMP:   if (any_fault) nxt = ST_SEVERE; else if (last_accept) nxt = ST_HOLD;
      ST_HOLD:   if (any_fault) nxt = ST_SEVERE; else if (host_clear)  nxt = ST_RUN;
      ST_SEVERE: nxt = ST_SEVERE;
      default:   nxt = ST_SEVERE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_RUN;
    else        st <= nxt;
  end

  assign tx_en      = (st == ST_RUN);
  assign rx_en      = (st == ST_RUN);
  assign find_req   = (st == ST_FIND);
  assign pass_req   = (st == ST_PASS);
  assign severe     = (st == ST_SEVERE);
  assign err_status = (st == ST_HOLD) | severe;
  assign irq        = ((st == ST_HOLD) & irq_mask) | severe;
endmodule

// File: rtl/frs_chk.sv
module frs_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_master,
  input logic          bus_err_in,
  input logic          chip_sel,
  input logic          int_ack,
  input logic          offline,
  input logic          host_clear,
  input logic          irq_mask,
  input logic          dump_ready,
  input logic          tx_en,
  input logic          rx_en,
  input logic          pass_req,
  input logic          find_req,
  input logic          dump_valid,
  input logic [AW-1:0] dump_addr,
  input logic          err_status,
  input logic          irq,
  input logic          severe
);
  logic fault_seen;
  assign fault_seen = bus_master & (bus_err_in | chip_sel | int_ack);

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_req && find_req)); // R5

  AST_DUMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_valid && !dump_ready && !fault_seen) |=> (dump_valid && $stable(dump_addr))); // R8

  AST_ENABLES_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && fault_seen) |=> (!tx_en && !rx_en)); // R3

  AST_OFFLINE_SEVERE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && fault_seen && offline) |=> (severe && !dump_valid && !pass_req && !find_req)); // R12

  AST_CLEAR_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (err_status && !severe && host_clear && !fault_seen) |=> (tx_en && rx_en && !err_status)); // R10

  AST_SEVERE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    severe |=> severe); // R11

  AST_SEVERE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    severe |-> (irq && err_status && !tx_en && !rx_en && !dump_valid)); // R13

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!severe && !irq_mask) |-> !irq); // R9

  AST_RUN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> (!dump_valid && !pass_req && !find_req && !err_status)); // R1
endmodule

bind fault_recovery_seq frs_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_master (bus_master),
  .bus_err_in (bus_err_in),
  .chip_sel   (chip_sel),
  .int_ack    (int_ack),
  .offline    (offline),
  .host_clear (host_clear),
  .irq_mask   (irq_mask),
  .dump_ready (dump_ready),
  .tx_en      (tx_en),
  .rx_en      (rx_en),
  .pass_req   (pass_req),
  .find_req   (find_req),
  .dump_valid (dump_valid),
  .dump_addr  (dump_addr),
  .err_status (err_status),
  .irq        (irq),
  .severe     (severe)
);

// File: tb/fault_recovery_seq_test.sv
module fault_recovery_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPTR = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic bus_master = 0, bus_err_in = 0, chip_sel = 0, int_ack = 0;
  logic offline = 0, token_held = 0, succ_known = 0, host_clear = 0, irq_mask = 0;
  logic pass_done = 0, find_done = 0, dump_ready = 0;
  logic [NPTR*32-1:0] ptr_flat = '0;
  logic [NPTR*16-1:0] fc_flat = '0;
  logic tx_en, rx_en, pass_req, find_req, dump_valid, err_status, irq, severe;
  logic [7:0]  dump_addr;
  logic [31:0] dump_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_recovery_seq uut (
    .clk(clk), .rst_n(rst_n), .bus_master(bus_master), .bus_err_in(bus_err_in),
    .chip_sel(chip_sel), .int_ack(int_ack), .offline(offline), .token_held(token_held),
    .succ_known(succ_known), .host_clear(host_clear), .irq_mask(irq_mask),
    .pass_done(pass_done), .find_done(find_done), .ptr_flat(ptr_flat), .fc_flat(fc_flat),
    .dump_ready(dump_ready), .tx_en(tx_en), .rx_en(rx_en), .pass_req(pass_req),
    .find_req(find_req), .dump_valid(dump_valid), .dump_addr(dump_addr),
    .dump_data(dump_data), .err_status(err_status), .irq(irq), .severe(severe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_addr(input int k);
    return 8'hE0 + 8'(6 * (k / 2)) + ((k % 2 == 1) ? 8'd2 : 8'd0);
  endfunction

  function automatic logic [31:0] exp_data(input int k);
    if (k % 2 == 0) return {16'h0, fc_flat[(k/2)*16 +: 16]};
    return ptr_flat[(k/2)*32 +: 32];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    bus_master = 0; bus_err_in = 0; chip_sel = 0; int_ack = 0;
    host_clear = 0; pass_done = 0; find_done = 0; dump_ready = 0; offline = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // Drive a fault for one edge; src 0 bus error, 1 chip select, 2 int ack.
  task automatic inject(input int src);
    bus_master = 1;
    bus_err_in = (src == 0);
    chip_sel   = (src == 1);
    int_ack    = (src == 2);
  endtask

  task automatic quiet();
    bus_master = 0; bus_err_in = 0; chip_sel = 0; int_ack = 0;
  endtask

  // mode 0: normal clear; 1: second fault together with clear; 2: second fault mid-dump
  task automatic recover(input int src, input bit tok, input bit succ, input bit msk, input int mode);
    int k;
    int guard;
    for (int i = 0; i < NPTR; i++) begin
      ptr_flat[i*32 +: 32] = $urandom;
      fc_flat[i*16 +: 16]  = 16'($urandom);
    end
    @(negedge clk);
    token_held = tok; succ_known = succ; irq_mask = msk;
    inject(src);
    @(negedge clk);
    quiet();
    chk(!tx_en && !rx_en, "R3 enables off after fault", {tx_en, rx_en}, 0);
    if (tok) begin
      if (!succ) begin
        chk(find_req && !pass_req, "R5 search requested first", {find_req, pass_req}, 2);
        repeat ($urandom_range(0, 3)) begin
          @(negedge clk);
          chk(find_req && !tx_en, "R5 search held until done", find_req, 1);
        end
        find_done = 1;
        @(negedge clk);
        find_done = 0;
      end
      chk(pass_req && !find_req && !dump_valid, "R4 pass requested", {pass_req, find_req}, 2);
      repeat ($urandom_range(0, 3)) begin
        @(negedge clk);
        chk(pass_req, "R4 pass held until done", pass_req, 1);
      end
      pass_done = 1;
      @(negedge clk);
      pass_done = 0;
    end else begin
      chk(dump_valid && !pass_req && !find_req, "R6 dump starts at once", {dump_valid, pass_req, find_req}, 4);
    end
    k = 0;
    guard = 0;
    while (k < 2 * NPTR && guard < 200) begin
      bit r;
      guard++;
      chk(dump_valid === 1'b1, "R8 valid held", dump_valid, 1);
      chk(dump_addr === exp_addr(k), "R7 dump address", dump_addr, exp_addr(k));
      chk(dump_data === exp_data(k), "R7 dump data", dump_data, exp_data(k));
      if (mode == 2 && k == 3) begin
        dump_ready = 0;
        inject(1);
        @(negedge clk);
        quiet();
        chk(severe && !dump_valid, "R11 second fault mid-dump", {severe, dump_valid}, 2);
        chk(irq, "R13 severe irq ignores mask", irq, 1);
        host_clear = 1;
        @(negedge clk);
        host_clear = 0;
        @(negedge clk);
        chk(severe && !tx_en, "R11 severe survives clear", {severe, tx_en}, 2);
        do_reset();
        return;
      end
      r = ($urandom_range(0, 2) != 0);
      dump_ready = r;
      @(negedge clk);
      if (r) k++;
    end
    dump_ready = 0;
    chk(!dump_valid && err_status, "R9 status after dump", {dump_valid, err_status}, 1);
    chk(irq === msk, "R9 irq follows mask", irq, msk);
    chk(!tx_en, "R3 enables still off before clear", tx_en, 0);
    repeat ($urandom_range(0, 3)) @(negedge clk);
    host_clear = 1;
    if (mode == 1) inject(0);
    @(negedge clk);
    host_clear = 0;
    quiet();
    if (mode == 1) begin
      chk(severe && err_status && irq && !tx_en, "R11 fault with clear escalates", severe, 1);
      do_reset();
    end else begin
      chk(tx_en && rx_en && !err_status && !irq, "R10 clear resumes", {tx_en, rx_en, err_status, irq}, 12);
    end
  endtask

  initial begin
    void'($urandom(32'd4917));
    do_reset();
    chk(tx_en && rx_en, "R1 enables after reset", {tx_en, rx_en}, 3);
    chk(!pass_req && !find_req && !dump_valid, "R1 no activity after reset", {pass_req, find_req, dump_valid}, 0);
    chk(!err_status && !irq && !severe, "R1 status clear after reset", {err_status, irq, severe}, 0);

    // R2: fault inputs without bus ownership, and a stray clear, are ignored
    bus_err_in = 1; chip_sel = 1; int_ack = 1; host_clear = 1;
    repeat (3) @(negedge clk);
    chk(tx_en && !err_status && !dump_valid, "R2 no fault without bus_master", tx_en, 1);
    quiet(); host_clear = 0;
    bus_master = 1;
    repeat (2) @(negedge clk);
    chk(tx_en, "R2 bus_master alone is no fault", tx_en, 1);
    bus_master = 0;

    // Directed sources and token cases
    recover(0, 1, 1, 1, 0);
    recover(1, 1, 0, 0, 0);
    recover(2, 0, 0, 1, 0);
    recover(1, 0, 1, 0, 0);

    // Random recoveries
    for (int n = 0; n < 24; n++)
      recover($urandom_range(0, 2), 1'($urandom), 1'($urandom), 1'($urandom), 0);

    // Second fault during dump, and together with clear
    recover(0, 0, 0, 0, 2);
    chk(!severe && tx_en, "R1 reset leaves severe", {severe, tx_en}, 1);
    recover(2, 1, 1, 0, 1);

    // Second fault during the token step
    @(negedge clk);
    token_held = 1; succ_known = 0; inject(0);
    @(negedge clk);
    chk(find_req, "R5 search before escalation", find_req, 1);
    inject(1);
    @(negedge clk);
    quiet();
    chk(severe && !find_req, "R11 fault during search", {severe, find_req}, 2);
    do_reset();

    // Offline fault
    offline = 1; irq_mask = 0; token_held = 1; succ_known = 1;
    inject(2);
    @(negedge clk);
    quiet();
    chk(severe && !pass_req && !find_req && !dump_valid, "R12 offline goes severe", {severe, pass_req, dump_valid}, 4);
    chk(irq && err_status && !tx_en && !rx_en, "R13 severe outputs", {irq, err_status, tx_en}, 6);
    repeat (3) @(negedge clk);
    chk(severe && irq, "R13 severe persists", {severe, irq}, 3);
    do_reset();
    chk(!severe && !irq && tx_en, "R1 clean after reset", {severe, irq, tx_en}, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule